// File: doc/BRIEF.md
# Chip-Select-Limited Burst Splitter

This block sits between a request arbiter and a HyperBus-style memory engine. It takes one transfer request at a time and hands the engine a series of sub-burst commands. A request holds a start address, a byte count, a bank, a requester id and a locked flag. Each command holds an address, a length and a last marker. No single command is longer than the limit for its bank and requester. This keeps chip select low for less than the RAM refresh window, and it keeps a long low-priority transfer from holding the bus.

The effective limit is the bank's burst limit shifted right by the current clock divider, capped by the requester's own limit. The block takes this value once, when it accepts the request. After each sub-burst the engine's done strobe moves the address forward by the bytes moved, and the bank's address mask wraps it inside the bank. A locked requester, such as a display refill, gets its next command the cycle after done. Any other requester is parked with its state held, and the block raises `suspended` until the arbiter grants it again. A zero-length request finishes without issuing any command.

Top module: `burstSplitter`

## Requirements
- R1: After reset `reqReady` is 1 and `cmdValid`, `suspended` and `reqDone` are 0.
- R2: The effective limit is min(`bankLimit` slice of the bank >> `clkDiv`, `reqLimit` slice of the requester). A result of 0 is raised to 1. The slice for index k is bits [k*W +: W]. The number of sub-bursts equals ceil(count / effective limit).
- R3: Each command length is min(remaining bytes, effective limit). `cmdLast` is 1 exactly when that length empties the request.
- R4: The first command address is the request address. Each later command address is (previous address + previous length) AND the bank's mask, where the mask for bank k is `bankMask` bits [k*ADDR_W +: ADDR_W].
- R5: For a locked request with bytes left, `cmdValid` is 1 in the cycle after the `engDone` cycle, and `suspended` stays 0.
- R6: For a non-locked request with bytes left, `suspended` is 1 from the cycle after `engDone`. No command is offered until an `arbGrant` cycle, and the next command is offered in the cycle after it.
- R7: A request with count 0 raises `reqDone` in the cycle after acceptance, with no command ever offered.
- R8: `reqDone` is a one-cycle pulse in the cycle after the final `engDone`. `reqReady` is 0 from acceptance until the cycle after `reqDone`.
- R9: Changes to `clkDiv`, `reqLimit` or `bankLimit` after acceptance do not alter the command sequence of that request. A parked and resumed request yields the same sequence as an uninterrupted one.
- R10: While `cmdValid` is 1 and `cmdReady` is 0, the command stays offered and `cmdAddr`, `cmdLen` and `cmdLast` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| clkDiv | input | DIV_W | Current clock divider shift applied to bank limits |
| bankLimit | input | NUM_BANKS*CNT_W | Per-bank burst limit in bytes, packed by bank |
| bankMask | input | NUM_BANKS*ADDR_W | Per-bank address wrap mask, packed by bank |
| reqLimit | input | NUM_REQ*CNT_W | Per-requester burst limit in bytes, packed by id |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle and accepting a request |
| reqAddr | input | ADDR_W | Request start address |
| reqCount | input | CNT_W | Request byte count |
| reqBank | input | BANK_W | Target bank |
| reqId | input | ID_W | Requester id |
| reqLocked | input | 1 | Requester chains sub-bursts without re-arbitration |
| cmdValid | output | 1 | Sub-burst command offered to the engine |
| cmdReady | input | 1 | Engine takes the command |
| cmdAddr | output | ADDR_W | Sub-burst start address |
| cmdLen | output | CNT_W | Sub-burst length in bytes |
| cmdLast | output | 1 | This sub-burst ends the request |
| engDone | input | 1 | Engine finished the current sub-burst |
| suspended | output | 1 | Request parked, waiting for re-arbitration |
| arbGrant | input | 1 | Arbiter lets the parked request continue |
| reqDone | output | 1 | Request finished pulse |

## Verification
The hardest state to reach is a parked request whose configuration has changed under it. The arbiter has to stay silent while the clock divider and the requester limit move, and the resumed commands must still follow the values taken at acceptance. The bench gets there by driving a non-locked request to its first park, then rewriting `clkDiv` and `reqLimit` and waiting several cycles before granting. It compares every later command with a model built from the original settings. The bench also reaches address wrap at a bank edge and a limit that clamps to 1, by choosing small masks and a zero requester limit.

// File: rtl/burstSplitPkg.sv
package burstSplitPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_PARK,
    ST_FINISH
  } splitState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
  } ctlStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic isLast;
    logic locked;
  } dpStatus_t;

endpackage

// File: rtl/burstSplitData.sv
module burstSplitData
  import burstSplitPkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int CNT_W     = 16,
  parameter int NUM_BANKS = 4,
  parameter int NUM_REQ   = 4,
  parameter int DIV_W     = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ID_W     = $clog2(NUM_REQ)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [DIV_W-1:0]              clkDiv,
  input  logic [NUM_BANKS*CNT_W-1:0]    bankLimit,
  input  logic [NUM_BANKS*ADDR_W-1:0]   bankMask,
  input  logic [NUM_REQ*CNT_W-1:0]      reqLimit,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [CNT_W-1:0]              reqCount,
  input  logic [BANK_W-1:0]             reqBank,
  input  logic [ID_W-1:0]               reqId,
  input  logic                          reqLocked,
  input  ctlStrobe_t                    strobe,
  output dpStatus_t                     status,
  output logic [ADDR_W-1:0]             curAddr,
  output logic [CNT_W-1:0]              curLen
);

  logic [CNT_W-1:0]  bankLimArr  [NUM_BANKS];
  logic [ADDR_W-1:0] bankMaskArr [NUM_BANKS];
  logic [CNT_W-1:0]  reqLimArr   [NUM_REQ];

  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      assign bankLimArr[gb]  = bankLimit[gb*CNT_W +: CNT_W];
      assign bankMaskArr[gb] = bankMask[gb*ADDR_W +: ADDR_W];
    end
  endgenerate

  genvar gr;
  generate
    for (gr = 0; gr < NUM_REQ; gr++) begin : g_req
      assign reqLimArr[gr] = reqLimit[gr*CNT_W +: CNT_W];
    end
  endgenerate

  logic [CNT_W-1:0]  scaledLim;
  logic [CNT_W-1:0]  minLim;
  logic [CNT_W-1:0]  effNext;
  logic [CNT_W-1:0]  remain;
  logic [CNT_W-1:0]  effLimit;
  logic [ADDR_W-1:0] maskReg;
  logic              lockedReg;

  always_comb begin
    scaledLim = bankLimArr[reqBank] >> clkDiv;
    minLim    = (scaledLim < reqLimArr[reqId]) ? scaledLim : reqLimArr[reqId];
    effNext   = (minLim == '0) ? CNT_W'(1) : minLim;
  end

  assign curLen        = (remain < effLimit) ? remain : effLimit;
  assign status.isLast = (remain <= effLimit);
  assign status.locked = lockedReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      remain    <= '0;
      effLimit  <= CNT_W'(1);
      maskReg   <= '0;
      lockedReg <= 1'b0;
    end else if (strobe.load) begin
      curAddr   <= reqAddr;
      remain    <= reqCount;
      effLimit  <= effNext;
      maskReg   <= bankMaskArr[reqBank];
      lockedReg <= reqLocked;
    end else if (strobe.advance) begin
      remain  <= remain - curLen;
      curAddr <= (curAddr + ADDR_W'(curLen)) & maskReg;
    end
  end

  AST_LAST_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && status.isLast) |=> (remain == '0)); // R3

  AST_MORE_LEFT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !status.isLast) |=> (remain != '0)); // R3

  AST_ADDR_IN_BANK: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> ((curAddr & ~maskReg) == '0)); // R4

  AST_LIMIT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (effLimit != '0)); // R2

endmodule

// File: rtl/burstSplitCtrl.sv
module burstSplitCtrl
  import burstSplitPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqCountZero,
  input  logic       cmdReady,
  input  logic       engDone,
  input  logic       arbGrant,
  input  dpStatus_t  status,
  output logic       reqReady,
  output logic       cmdValid,
  output logic       suspended,
  output logic       reqDone,
  output ctlStrobe_t strobe
);

  splitState_t state, stateNext;

  always_comb begin
    stateNext      = state;
    strobe.load    = 1'b0;
    strobe.advance = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          stateNext   = reqCountZero ? ST_FINISH : ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (cmdReady) stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        if (engDone) begin
          strobe.advance = 1'b1;
          if (status.isLast)      stateNext = ST_FINISH;
          else if (status.locked) stateNext = ST_ISSUE;
          else                    stateNext = ST_PARK;
        end
      end
      ST_PARK: begin
        if (arbGrant) stateNext = ST_ISSUE;
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady  = (state == ST_IDLE);
  assign cmdValid  = (state == ST_ISSUE);
  assign suspended = (state == ST_PARK);
  assign reqDone   = (state == ST_FINISH);

  AST_LOCKED_NEVER_PARKS: assert property (@(posedge clk) disable iff (!rstN)
    suspended |-> !status.locked); // R5

  AST_PARK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (suspended && !arbGrant) |=> (suspended && !cmdValid)); // R6

  AST_ZERO_NO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqCountZero) |=> (reqDone && !cmdValid)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> (!reqDone && reqReady)); // R8

endmodule

// File: rtl/burstSplitter.sv
module burstSplitter
  import burstSplitPkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int CNT_W     = 16,
  parameter int NUM_BANKS = 4,
  parameter int NUM_REQ   = 4,
  parameter int DIV_W     = 2,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int ID_W     = $clog2(NUM_REQ)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [DIV_W-1:0]              clkDiv,
  input  logic [NUM_BANKS*CNT_W-1:0]    bankLimit,
  input  logic [NUM_BANKS*ADDR_W-1:0]   bankMask,
  input  logic [NUM_REQ*CNT_W-1:0]      reqLimit,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [CNT_W-1:0]              reqCount,
  input  logic [BANK_W-1:0]             reqBank,
  input  logic [ID_W-1:0]               reqId,
  input  logic                          reqLocked,
  output logic                          cmdValid,
  input  logic                          cmdReady,
  output logic [ADDR_W-1:0]             cmdAddr,
  output logic [CNT_W-1:0]              cmdLen,
  output logic                          cmdLast,
  input  logic                          engDone,
  output logic                          suspended,
  input  logic                          arbGrant,
  output logic                          reqDone
);

  ctlStrobe_t strobe;
  dpStatus_t  status;

  burstSplitCtrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqCountZero (reqCount == '0),
    .cmdReady     (cmdReady),
    .engDone      (engDone),
    .arbGrant     (arbGrant),
    .status       (status),
    .reqReady     (reqReady),
    .cmdValid     (cmdValid),
    .suspended    (suspended),
    .reqDone      (reqDone),
    .strobe       (strobe)
  );

  burstSplitData #(
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W),
    .NUM_BANKS (NUM_BANKS),
    .NUM_REQ   (NUM_REQ),
    .DIV_W     (DIV_W)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .clkDiv    (clkDiv),
    .bankLimit (bankLimit),
    .bankMask  (bankMask),
    .reqLimit  (reqLimit),
    .reqAddr   (reqAddr),
    .reqCount  (reqCount),
    .reqBank   (reqBank),
    .reqId     (reqId),
    .reqLocked (reqLocked),
    .strobe    (strobe),
    .status    (status),
    .curAddr   (cmdAddr),
    .curLen    (cmdLen)
  );

  assign cmdLast = status.isLast;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdAddr) && $stable(cmdLen)
                                 && $stable(cmdLast))); // R10

endmodule

// File: tb/sim_burstSplitter.sv
module sim_burstSplitter;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;
  localparam int CNT_W  = 16;
  localparam int NB     = 4;
  localparam int NR     = 4;

  // addr | count | bank | id | locked | div | pad | expected sub-bursts
  localparam logic [63:0] VEC [12] = '{
    {24'h000100, 16'd768,   2'd0, 2'd0, 1'b0, 2'd0, 9'd0, 8'd3},
    {24'h000000, 16'd768,   2'd0, 2'd1, 1'b1, 2'd0, 9'd0, 8'd1},
    {24'h000000, 16'd768,   2'd0, 2'd1, 1'b1, 2'd2, 9'd0, 8'd3},
    {24'h0003F0, 16'd200,   2'd2, 2'd0, 1'b0, 2'd0, 9'd0, 8'd3},
    {24'h000010, 16'd65535, 2'd1, 2'd1, 1'b1, 2'd0, 9'd0, 8'd1},
    {24'h00FFC0, 16'd250,   2'd3, 2'd2, 1'b0, 2'd1, 9'd0, 8'd3},
    {24'h000020, 16'd3,     2'd3, 2'd3, 1'b1, 2'd0, 9'd0, 8'd3},
    {24'h000040, 16'd0,     2'd0, 2'd0, 1'b0, 2'd0, 9'd0, 8'd0},
    {24'h000000, 16'd255,   2'd0, 2'd0, 1'b0, 2'd0, 9'd0, 8'd1},
    {24'h000000, 16'd257,   2'd0, 2'd0, 1'b0, 2'd0, 9'd0, 8'd2},
    {24'h000000, 16'd256,   2'd0, 2'd0, 1'b0, 2'd0, 9'd0, 8'd1},
    {24'h0003FA, 16'd30,    2'd2, 2'd1, 1'b1, 2'd3, 9'd0, 8'd3}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] clkDiv = '0;
  logic [NB*CNT_W-1:0]  bankLimitBus;
  logic [NB*ADDR_W-1:0] bankMaskBus;
  logic [NR*CNT_W-1:0]  reqLimitBus;
  logic reqValid = 1'b0, reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [CNT_W-1:0]  reqCount = '0;
  logic [1:0] reqBank = '0, reqId = '0;
  logic reqLocked = 1'b0;
  logic cmdValid, cmdReady = 1'b0, cmdLast;
  logic [ADDR_W-1:0] cmdAddr;
  logic [CNT_W-1:0]  cmdLen;
  logic engDone = 1'b0, suspended, arbGrant = 1'b0, reqDone;

  int bankLim [NB] = '{1024, 65535, 96, 512};
  logic [ADDR_W-1:0] bankMsk [NB] = '{24'h0FFFFF, 24'hFFFFFF, 24'h0003FF, 24'h00FFFF};
  int reqLim [NR] = '{256, 65535, 100, 0};

  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_cfgB
      assign bankLimitBus[gi*CNT_W +: CNT_W]  = CNT_W'(bankLim[gi]);
      assign bankMaskBus[gi*ADDR_W +: ADDR_W] = bankMsk[gi];
    end
    for (gi = 0; gi < NR; gi++) begin : g_cfgR
      assign reqLimitBus[gi*CNT_W +: CNT_W] = CNT_W'(reqLim[gi]);
    end
  endgenerate

  always #(CLK_PERIOD/2) clk = ~clk;

  burstSplitter u0 (
    .clk(clk), .rstN(rstN), .clkDiv(clkDiv), .bankLimit(bankLimitBus),
    .bankMask(bankMaskBus), .reqLimit(reqLimitBus), .reqValid(reqValid),
    .reqReady(reqReady), .reqAddr(reqAddr), .reqCount(reqCount),
    .reqBank(reqBank), .reqId(reqId), .reqLocked(reqLocked),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdAddr(cmdAddr),
    .cmdLen(cmdLen), .cmdLast(cmdLast), .engDone(engDone),
    .suspended(suspended), .arbGrant(arbGrant), .reqDone(reqDone)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int effModel(input int bk, input int id, input int dv);
    int s, m;
    s = bankLim[bk] >> dv;
    m = (s < reqLim[id]) ? s : reqLim[id];
    return (m == 0) ? 1 : m;
  endfunction

  task automatic runReq(input logic [ADDR_W-1:0] a0, input int cnt, input int bk,
                        input int id, input bit lk, input int dv, input int expSubs,
                        input bit stall, input bit perturb);
    int eff, remain, len, subs, savedLim;
    logic [ADDR_W-1:0] a, mask, holdAddr;
    eff = effModel(bk, id, dv);
    mask = bankMsk[bk];
    remain = cnt; a = a0; subs = 0; savedLim = reqLim[id];
    @(negedge clk);
    chk(reqReady == 1'b1, "R8", "ready before request", reqReady, 1);
    clkDiv = 2'(dv); reqAddr = a0; reqCount = CNT_W'(cnt);
    reqBank = 2'(bk); reqId = 2'(id); reqLocked = lk; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (cnt == 0) begin
      chk(reqDone == 1'b1, "R7", "done after zero request", reqDone, 1);
      chk(cmdValid == 1'b0, "R7", "no command for zero request", cmdValid, 0);
    end else begin
      chk(reqReady == 1'b0, "R8", "ready while busy", reqReady, 0);
    end
    while (remain > 0) begin
      len = (remain < eff) ? remain : eff;
      chk(cmdValid == 1'b1, "R3", "command offered", cmdValid, 1);
      chk(cmdLen == CNT_W'(len), "R3", "length", cmdLen, len);
      chk(cmdLast == (len == remain), "R3", "last flag", cmdLast, (len == remain));
      chk(cmdAddr == a, "R4", "address", cmdAddr, a);
      if (perturb && subs > 0)
        chk(cmdLen == CNT_W'(len), "R9", "length after reconfig", cmdLen, len);
      if (stall && subs == 0) begin
        holdAddr = cmdAddr;
        repeat (3) @(negedge clk);
        chk(cmdValid == 1'b1 && cmdAddr == holdAddr && cmdLen == CNT_W'(len),
            "R10", "command held under back-pressure", cmdAddr, holdAddr);
      end
      cmdReady = 1'b1;
      @(negedge clk);
      cmdReady = 1'b0;
      chk(cmdValid == 1'b0, "R3", "command withdrawn after take", cmdValid, 0);
      @(negedge clk);
      engDone = 1'b1;
      @(negedge clk);
      engDone = 1'b0;
      remain -= len;
      a = (a + ADDR_W'(len)) & mask;
      subs++;
      if (remain == 0) begin
        chk(reqDone == 1'b1, "R8", "done after last sub-burst", reqDone, 1);
      end else if (lk) begin
        chk(cmdValid == 1'b1 && suspended == 1'b0, "R5", "locked chains",
            {cmdValid, suspended}, 2'b10);
      end else begin
        chk(suspended == 1'b1 && cmdValid == 1'b0 && reqReady == 1'b0, "R6",
            "parked after sub-burst", {suspended, cmdValid, reqReady}, 3'b100);
        if (perturb) begin
          clkDiv = 2'd3;
          reqLim[id] = 7;
        end
        repeat (3) @(negedge clk);
        chk(suspended == 1'b1 && cmdValid == 1'b0, "R6", "stays parked without grant",
            {suspended, cmdValid}, 2'b10);
        arbGrant = 1'b1;
        @(negedge clk);
        arbGrant = 1'b0;
      end
    end
    chk(subs == expSubs, "R2", "sub-burst count", subs, expSubs);
    @(negedge clk);
    chk(reqDone == 1'b0 && reqReady == 1'b1, "R8", "done is a pulse",
        {reqDone, reqReady}, 2'b01);
    reqLim[id] = savedLim;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1, "R1", "reset ready", reqReady, 1);
    chk(cmdValid == 1'b0 && suspended == 1'b0 && reqDone == 1'b0, "R1",
        "reset outputs idle", {cmdValid, suspended, reqDone}, 0);

    for (int i = 0; i < 12; i++) begin
      runReq(VEC[i][63:40], int'(VEC[i][39:24]), int'(VEC[i][23:22]),
             int'(VEC[i][21:20]), VEC[i][19], int'(VEC[i][18:17]),
             int'(VEC[i][7:0]), 1'b0, 1'b0);
    end

    // R9: reconfigure while parked; sequence must follow settings at acceptance
    runReq(24'h000100, 768, 0, 0, 1'b0, 0, 3, 1'b0, 1'b1);
    // R10: back-pressure on the first command, with wrap at a bank edge
    runReq(24'h0003C0, 150, 2, 2, 1'b0, 0, 2, 1'b1, 1'b0);
    // R2: bank limit scaled below requester limit
    runReq(24'h000000, 100, 3, 0, 1'b1, 3, 2, 1'b0, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule